// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous up-counter assembled from identical 4-bit stages. Every stage holds its bits in flip-flops that share one rising clock edge, so all output bits change together. A parallel value can be preset at a clock edge through an active-low load pin. An active-low clear pin empties the whole counter at once, without waiting for the clock.

Counting is gated by two enables. The shared enable goes to every stage. The chain enable feeds only the first stage. Each stage drives a carry that is high while that stage sits at its all-ones value and its own chain enable is high. That carry becomes the chain enable of the next stage, so the stages together behave as one counter of `STAGES*STAGE_W` bits with no extra gating between them. The last carry leaves the block so that further counters can be chained onto it.

All pins are plain level controls. The block has no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `cascade_counter`

## Requirements
- R1: The count changes only at a rising clock edge, and all of its bits update at that edge. Moving the load or enable pins between edges and returning them before the edge leaves the count unchanged.
- R2: While `clr_n` is 0 the count is 0, as soon as the pin falls and at any clock phase. Clear has priority over load and both enables.
- R3: With `clr_n` at 1 and `ld_n` at 0, the next rising edge copies `ld_val` into the count, whatever levels the two enables have.
- R4: With `ld_n` at 1 and both `en_all` and `en_chain` at 1, the next rising edge adds one to the count. The all-ones value wraps to 0.
- R5: With `ld_n` at 1 and either enable at 0, the count keeps its value across the edge.
- R6: `carry_out` is 1 exactly when the count is all ones and `en_chain` is 1. It does not depend on `en_all`, and it follows its inputs within the same cycle, because it is decoded and not stored.
- R7: The carry of stage k (bits k*STAGE_W and up) is the chain enable of stage k+1. A stage therefore advances only when every lower stage is at all ones. A lower stage at all ones does not by itself raise `carry_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state updates on its rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| ld_n | input | 1 | Synchronous preset, active low |
| en_all | input | 1 | Count enable shared by every stage |
| en_chain | input | 1 | Count enable of the first stage; also gates the carry |
| ld_val | input | STAGES*STAGE_W | Value copied into the count on a preset |
| cnt_q | output | STAGES*STAGE_W | Current count |
| carry_out | output | 1 | Terminal-count carry of the last stage |

## Verification
The bench presets the count to 252 and steps it through 253, 254, 255, 0, 1 and 2. A design with a registered or wrongly gated carry would pulse the carry one cycle late, or in more than the single all-ones cycle. A preset with both enables low would leave an enable-gated load stuck at the old value. Presetting 0x0F and 0xEF targets the stage boundary: a wrong chain connection would fail to carry into the upper nibble, or would raise the final carry when only the lower nibble is full. The bench drops clear in mid-cycle and glitches the controls between edges, which catches a synchronous clear and any sensitivity to levels that change between edges.

// File: rtl/cascade_counter_pkg.sv
package cascade_counter_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'd0,
    MODE_STEP = 2'd1,
    MODE_LOAD = 2'd2
  } step_mode_e;
endpackage

// File: rtl/cnt_mode_sel.sv
module cnt_mode_sel
  import cascade_counter_pkg::*;
(
  input  logic       ld_n,
  input  logic       en_all,
  input  logic       chain_in,
  output step_mode_e mode
);
  // Preset wins over counting; counting needs both enables.
  always_comb begin
    if (!ld_n)                   mode = MODE_LOAD;
    else if (en_all && chain_in) mode = MODE_STEP;
    else                         mode = MODE_HOLD;
  end
endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
  import cascade_counter_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         ld_n,
  input  logic         en_all,
  input  logic         chain_in,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         carry
);
  step_mode_e   mode;
  logic [W-1:0] nxt;

  cnt_mode_sel u_sel (
    .ld_n     (ld_n),
    .en_all   (en_all),
    .chain_in (chain_in),
    .mode     (mode)
  );

  always_comb begin
    unique case (mode)
      MODE_LOAD: nxt = d;
      MODE_STEP: nxt = q + W'(1);
      default:   nxt = q;
    endcase
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q <= '0;
    else        q <= nxt;
  end

  // Terminal count decode, gated only by this stage's chain enable.
  assign carry = chain_in & (&q);
endmodule

// File: rtl/cascade_counter.sv
module cascade_counter #(
  parameter int STAGES  = 2,
  parameter int STAGE_W = 4,
  localparam int W      = STAGES * STAGE_W
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         ld_n,
  input  logic         en_all,
  input  logic         en_chain,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt_q,
  output logic         carry_out
);
  logic [STAGES:0] chain;

  assign chain[0] = en_chain;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    cnt_stage #(.W(STAGE_W)) u_stg (
      .clk      (clk),
      .clr_n    (clr_n),
      .ld_n     (ld_n),
      .en_all   (en_all),
      .chain_in (chain[g]),
      .d        (ld_val[g*STAGE_W +: STAGE_W]),
      .q        (cnt_q[g*STAGE_W +: STAGE_W]),
      .carry    (chain[g+1])
    );
  end

  assign carry_out = chain[STAGES];
endmodule

// File: rtl/cascade_counter_chk.sv
module cascade_counter_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         clr_n,
  input logic         ld_n,
  input logic         en_all,
  input logic         en_chain,
  input logic [W-1:0] ld_val,
  input logic [W-1:0] cnt_q,
  input logic         carry_out
);
  assert_clear_R2: assert property (@(posedge clk) !clr_n |-> cnt_q == '0)
    else $error("clear did not empty the count");

  assert_load_R3: assert property (@(posedge clk) disable iff (!clr_n)
    !ld_n |=> cnt_q == $past(ld_val))
    else $error("preset value not taken");

  assert_step_R4: assert property (@(posedge clk) disable iff (!clr_n)
    (ld_n && en_all && en_chain) |=> cnt_q == $past(cnt_q) + W'(1))
    else $error("count did not advance by one");

  assert_hold_R5: assert property (@(posedge clk) disable iff (!clr_n)
    (ld_n && !(en_all && en_chain)) |=> $stable(cnt_q))
    else $error("count moved while disabled");

  assert_carry_R6: assert property (@(posedge clk) disable iff (!clr_n)
    carry_out == (en_chain && (&cnt_q)))
    else $error("carry does not match terminal count");

  assert_chain_top_R7: assert property (@(posedge clk) disable iff (!clr_n)
    carry_out |-> (&cnt_q))
    else $error("final carry raised before all stages full");
endmodule

bind cascade_counter cascade_counter_chk #(.W(W)) u_chk (
  .clk       (clk),
  .clr_n     (clr_n),
  .ld_n      (ld_n),
  .en_all    (en_all),
  .en_chain  (en_chain),
  .ld_val    (ld_val),
  .cnt_q     (cnt_q),
  .carry_out (carry_out)
);

// File: tb/tb_cascade_counter.sv
module tb_cascade_counter;
  localparam int STAGES  = 2;
  localparam int STAGE_W = 4;
  localparam int W       = STAGES * STAGE_W;

  logic         clk = 1'b0;
  logic         clr_n = 1'b0;
  logic         ld_n = 1'b1;
  logic         en_all = 1'b0;
  logic         en_chain = 1'b0;
  logic [W-1:0] ld_val = '0;
  logic [W-1:0] cnt_q;
  logic         carry_out;

  int           total = 0;
  int           bad = 0;
  logic [W-1:0] exp_q = '0;

  always #10 clk = ~clk;

  cascade_counter #(.STAGES(STAGES), .STAGE_W(STAGE_W)) dut (
    .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .en_all(en_all),
    .en_chain(en_chain), .ld_val(ld_val), .cnt_q(cnt_q), .carry_out(carry_out)
  );

  task automatic check_val(string tag, logic [W-1:0] got, logic [W-1:0] want);
    total++;
    if (got !== want) begin
      bad++;
      $display("FAIL %s count got=%0h exp=%0h", tag, got, want);
    end
  endtask

  task automatic check_bit(string tag, logic got, logic want);
    total++;
    if (got !== want) begin
      bad++;
      $display("FAIL %s carry got=%0b exp=%0b", tag, got, want);
    end
  endtask

  // Called at a falling edge with inputs already set; checks after the next rising edge.
  task automatic tick(string tag);
    logic [W-1:0] nxt;
    if (!clr_n)                    nxt = '0;
    else if (!ld_n)                nxt = ld_val;
    else if (en_all && en_chain)   nxt = exp_q + W'(1);
    else                           nxt = exp_q;
    @(posedge clk);
    exp_q = nxt;
    @(negedge clk);
    check_val(tag, cnt_q, exp_q);
    check_bit("R6", carry_out, en_chain && (&exp_q));
  endtask

  task automatic t_reset();
    @(negedge clk);
    @(negedge clk);
    check_val("R2", cnt_q, '0);
    check_bit("R6", carry_out, 1'b0);
    clr_n = 1'b1;
    exp_q = '0;
  endtask

  task automatic t_sequence();
    ld_n = 1'b0; ld_val = 8'd252; en_all = 1'b1; en_chain = 1'b1;
    tick("R3");
    ld_n = 1'b1;
    for (int i = 0; i < 6; i++) tick("R4");
    check_val("R4", cnt_q, 8'd2);
    en_chain = 1'b0;
    tick("R5");
    en_chain = 1'b1; en_all = 1'b0;
    tick("R5");
  endtask

  task automatic t_load_idle();
    en_all = 1'b0; en_chain = 1'b0; ld_n = 1'b0; ld_val = 8'hA5;
    tick("R3");
    ld_n = 1'b1;
    tick("R5");
  endtask

  task automatic t_stage_boundary();
    ld_n = 1'b0; ld_val = 8'h0F; en_all = 1'b1; en_chain = 1'b1;
    tick("R3");
    ld_n = 1'b1;
    tick("R7");
    check_val("R7", cnt_q, 8'h10);
    ld_n = 1'b0; ld_val = 8'hEF;
    tick("R3");
    check_bit("R7", carry_out, 1'b0);
    ld_n = 1'b1;
    tick("R7");
    check_val("R7", cnt_q, 8'hF0);
  endtask

  task automatic t_carry_par();
    ld_n = 1'b0; ld_val = 8'hFF; en_all = 1'b0; en_chain = 1'b1;
    tick("R3");
    ld_n = 1'b1;
    #2;
    check_bit("R6", carry_out, 1'b1);
    en_chain = 1'b0;
    #2;
    check_bit("R6", carry_out, 1'b0);
    en_chain = 1'b1;
    #2;
    check_bit("R6", carry_out, 1'b1);
    @(negedge clk);
    check_val("R5", cnt_q, 8'hFF);
    en_all = 1'b1;
    tick("R4");
    check_val("R4", cnt_q, 8'h00);
  endtask

  task automatic t_glitch();
    en_all = 1'b0; en_chain = 1'b0; ld_n = 1'b1;
    tick("R5");
    ld_n = 1'b0; ld_val = 8'h3C; en_all = 1'b1; en_chain = 1'b1;
    #3;
    ld_n = 1'b1; en_all = 1'b0; en_chain = 1'b0;
    #2;
    check_val("R1", cnt_q, exp_q);
    tick("R1");
  endtask

  task automatic t_midclear();
    ld_n = 1'b0; ld_val = 8'h37; en_all = 1'b1; en_chain = 1'b1;
    tick("R3");
    ld_n = 1'b1;
    @(posedge clk);
    exp_q = exp_q + W'(1);
    #5;
    clr_n = 1'b0;
    #1;
    check_val("R2", cnt_q, '0);
    exp_q = '0;
    @(negedge clk);
    ld_n = 1'b0; ld_val = 8'h99;
    tick("R2");
    clr_n = 1'b1; ld_n = 1'b1;
    tick("R4");
    check_val("R4", cnt_q, 8'h01);
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL R1 watchdog got=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_sequence();
    t_load_idle();
    t_stage_boundary();
    t_carry_par();
    t_glitch();
    t_midclear();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule